// File: doc/BRIEF.md
# Host Request Sequence Guard

This block sits between a host request bus and the request FIFO of a bus master. Each request carries a 3-bit tag and a 32-bit data word. The block sorts every request into one of three outlets: transfer requests go to the master FIFO, control requests go to a control outlet, and diagnostic messages go to a response outlet. It also enforces the framing of a transfer, which is one address, then any number of data words, then one closing data word.

The block rejects any request that breaks this framing. It drops the request and reports it with a status response. When the master signals that a transfer was aborted, the block discards what is left of that transfer, up to and including the closing word, and emits one flush response for each word it discards. It also holds back a second read transfer until the first read completes. Write transfers are not held back.

All three outlets use a valid/ready handshake with no storage. A request is consumed in the cycle in which its chosen outlet is ready.

Top module: `hreq_seq_guard`

## Requirements
- R1: After a synchronous active-low reset the block is idle with no read outstanding. While `req_valid` is low, `fwd_valid`, `ctl_valid` and `rsp_valid` are all low.
- R2: A tag 0 request is consumed at once (`req_ready` high) and produces nothing. It leaves the framing state unchanged.
- R3: A tag 1 request goes to the control outlet in any framing state and does not change that state. The fields are decoded as follows:
  - `ctl_fence` is high when data bits 17:16 are both 0.
  - `ctl_cfg_wr` is data bit 16 and `ctl_cfg_rd` is data bit 17.
  - The byte address is data bits 7:0.
  - The write byte is data bits 15:8.
  - The function number is data bits 20:18.
- R4: Legal transfer requests go to `fwd_tag`/`fwd_data` unchanged. A legal transfer is an address (tag 2 or 3) while idle, followed by data (tag 4 or 5) and a closing word (tag 6 or 7) while a burst is open. An address opens a burst and a closing word ends it.
- R5: An address request while a burst is open or being flushed is dropped. It produces a response with tag 3, data bit 16 set, bit 19 clear and bits 2:0 holding the offending tag.
- R6: A data or closing request while idle is dropped. It produces the same bit-16 response as R5. This covers a closing word followed by data, and a closing word followed by another closing word.
- R7: An `xfer_abort` sampled while a burst is open moves the block to flushing from the next cycle. Each later data or closing request of that transfer is then dropped and produces one response with tag 3, bit 19 set and bit 16 clear. The closing word returns the block to idle.
- R8: An abort is ignored in two cases: when it arrives while idle, and when it arrives in the same cycle that a closing word is consumed.
- R9: An address is a read when its data bit 0 is 0. Once a read address is consumed, a later read address is stalled while idle: `req_ready` is low and nothing is emitted. The stall lasts until the cycle after a `rd_done` pulse. Write addresses are not stalled.
- R10: `req_ready` follows the ready input of the outlet the request is routed to. Nothing is consumed while that outlet is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Host request consumed this cycle |
| req_tag | input | 3 | Host request tag |
| req_data | input | DATA_W | Host request data word |
| xfer_abort | input | 1 | Master or target abort of the current transfer |
| rd_done | input | 1 | Outstanding read has completed |
| fwd_valid | output | 1 | Transfer request to master FIFO |
| fwd_ready | input | 1 | Master FIFO can accept |
| fwd_tag | output | 3 | Forwarded tag |
| fwd_data | output | DATA_W | Forwarded data |
| ctl_valid | output | 1 | Control request present |
| ctl_ready | input | 1 | Control consumer can accept |
| ctl_fence | output | 1 | Control request is a write fence |
| ctl_cfg_wr | output | 1 | Configuration write |
| ctl_cfg_rd | output | 1 | Configuration read |
| ctl_cfg_addr | output | 8 | Configuration byte address |
| ctl_cfg_byte | output | 8 | Configuration write byte |
| ctl_cfg_func | output | 3 | Configuration function number |
| rsp_valid | output | 1 | Status response present |
| rsp_ready | input | 1 | Response channel can accept |
| rsp_tag | output | 4 | Response tag (always 3) |
| rsp_data | output | DATA_W | Response flags and offending tag |

## Verification
The routing and handshake outputs depend only on the current inputs and the registered framing state. They are therefore due in the same cycle as the request, and the bench compares them at the falling edge after driving the inputs just past the rising edge. An abort, a `rd_done` pulse and a consumed address or closing word only change the state one rising edge later. The reference model applies these changes at that edge, so an abort first affects the request compared in the following cycle, and a released read is first consumed one cycle after its `rd_done`.

// File: rtl/hreq_pkg.sv
// Shared types and constants for the host request sequence guard.
package hreq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_BURST = 2'd1,
        SQ_FLUSH = 2'd2
    } seq_state_t;

    typedef enum logic [2:0] {
        RC_SPARE = 3'd0,
        RC_CTL   = 3'd1,
        RC_ADDR  = 3'd2,
        RC_DATA  = 3'd3,
        RC_LAST  = 3'd4
    } req_class_t;

    localparam int unsigned TAG_W       = 3;
    localparam int unsigned RSP_TAG_W   = 4;
    localparam logic [3:0]  RSP_STATUS  = 4'h3;
    localparam int unsigned BIT_ILLEGAL = 16;
    localparam int unsigned BIT_FLUSH   = 19;
    localparam int unsigned MIN_DATA_W  = 21;
endpackage

// File: rtl/hreq_classify.sv
// Decodes a request tag into its class and splits out the control fields.
// Assumes DATA_W >= 21 so that all control fields exist in the data word.
module hreq_classify
    import hreq_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [TAG_W-1:0]  tag,
    input  logic [DATA_W-1:0] data,
    output req_class_t        cls,
    output logic              is_read,
    output logic              fence,
    output logic              cfg_wr,
    output logic              cfg_rd,
    output logic [7:0]        cfg_addr,
    output logic [7:0]        cfg_byte,
    output logic [2:0]        cfg_func
);
    localparam int unsigned SPARE_HI = DATA_W - 1;

    logic unused_hi;
    assign unused_hi = &{1'b0, data[SPARE_HI:MIN_DATA_W]};

    // Map the tag to a request class.
    always_comb begin
        unique case (tag)
            3'd0:       cls = RC_SPARE;
            3'd1:       cls = RC_CTL;
            3'd2, 3'd3: cls = RC_ADDR;
            3'd4, 3'd5: cls = RC_DATA;
            default:    cls = RC_LAST;
        endcase
    end

    // Command bit 0 clear marks a read address.
    assign is_read  = ~data[0];
    assign cfg_wr   = data[16];
    assign cfg_rd   = data[17];
    assign fence    = ~(data[16] | data[17]);
    assign cfg_addr = data[7:0];
    assign cfg_byte = data[15:8];
    assign cfg_func = data[20:18];
endmodule

// File: rtl/hreq_seq_fsm.sv
// Framing state (idle / burst open / flushing) and the outstanding-read flag.
// Assumes acc is one only when a request is actually consumed.
module hreq_seq_fsm
    import hreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  req_class_t cls,
    input  logic       is_read,
    input  logic       abort,
    input  logic       rd_done,
    output seq_state_t st,
    output logic       rd_busy
);
    seq_state_t st_nx;

    // Next framing state from the consumed request and the abort line.
    always_comb begin
        st_nx = st;
        unique case (st)
            SQ_IDLE:  if (acc && cls == RC_ADDR) st_nx = SQ_BURST;
            SQ_BURST: begin
                if (acc && cls == RC_LAST) st_nx = SQ_IDLE;
                else if (abort)            st_nx = SQ_FLUSH;
            end
            SQ_FLUSH: if (acc && cls == RC_LAST) st_nx = SQ_IDLE;
            default:  st_nx = SQ_IDLE;
        endcase
    end

    // Register the framing state.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= st_nx;
    end

    // Track one outstanding read: set on a consumed read address, clear on done.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_busy <= 1'b0;
        else if (st == SQ_IDLE && acc && cls == RC_ADDR && is_read)
            rd_busy <= 1'b1;
        else if (rd_done)
            rd_busy <= 1'b0;
    end
endmodule

// File: rtl/hreq_route.sv
// Chooses the outlet for the current request and builds status responses.
// Purely combinational; assumes the state inputs are registered upstream.
module hreq_route
    import hreq_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              req_valid,
    input  logic [TAG_W-1:0]  req_tag,
    input  req_class_t        cls,
    input  logic              is_read,
    input  seq_state_t        st,
    input  logic              rd_busy,
    input  logic              fwd_ready,
    input  logic              ctl_ready,
    input  logic              rsp_ready,
    output logic              req_ready,
    output logic              fwd_valid,
    output logic              ctl_valid,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    // Route by class and framing state.
    always_comb begin
        req_ready = 1'b0;
        fwd_valid = 1'b0;
        ctl_valid = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = '0;
        rsp_data[TAG_W-1:0] = req_tag;
        unique case (cls)
            RC_SPARE: req_ready = 1'b1;
            RC_CTL: begin
                ctl_valid = req_valid;
                req_ready = ctl_ready;
            end
            RC_ADDR: begin
                if (st == SQ_IDLE) begin
                    if (!(is_read && rd_busy)) begin
                        fwd_valid = req_valid;
                        req_ready = fwd_ready;
                    end
                end else begin
                    rsp_valid = req_valid;
                    rsp_data[BIT_ILLEGAL] = 1'b1;
                    req_ready = rsp_ready;
                end
            end
            default: begin
                unique case (st)
                    SQ_BURST: begin
                        fwd_valid = req_valid;
                        req_ready = fwd_ready;
                    end
                    SQ_FLUSH: begin
                        rsp_valid = req_valid;
                        rsp_data[BIT_FLUSH] = 1'b1;
                        req_ready = rsp_ready;
                    end
                    default: begin
                        rsp_valid = req_valid;
                        rsp_data[BIT_ILLEGAL] = 1'b1;
                        req_ready = rsp_ready;
                    end
                endcase
            end
        endcase
    end
endmodule

// File: rtl/hreq_seq_guard.sv
// Host request sequence guard: checks address/data/closing framing, routes
// control requests apart from transfers, flushes aborted bursts.
// Assumes abort and rd_done are single-cycle pulses synchronous to clk.
module hreq_seq_guard
    import hreq_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [2:0]           req_tag,
    input  logic [DATA_W-1:0]    req_data,
    input  logic                 xfer_abort,
    input  logic                 rd_done,
    output logic                 fwd_valid,
    input  logic                 fwd_ready,
    output logic [2:0]           fwd_tag,
    output logic [DATA_W-1:0]    fwd_data,
    output logic                 ctl_valid,
    input  logic                 ctl_ready,
    output logic                 ctl_fence,
    output logic                 ctl_cfg_wr,
    output logic                 ctl_cfg_rd,
    output logic [7:0]           ctl_cfg_addr,
    output logic [7:0]           ctl_cfg_byte,
    output logic [2:0]           ctl_cfg_func,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [3:0]           rsp_tag,
    output logic [DATA_W-1:0]    rsp_data
);
    req_class_t cls;
    logic       is_read;
    seq_state_t st;
    logic       rd_busy;
    logic       acc;

    hreq_classify #(.DATA_W(DATA_W)) u_cls (
        .tag      (req_tag),
        .data     (req_data),
        .cls      (cls),
        .is_read  (is_read),
        .fence    (ctl_fence),
        .cfg_wr   (ctl_cfg_wr),
        .cfg_rd   (ctl_cfg_rd),
        .cfg_addr (ctl_cfg_addr),
        .cfg_byte (ctl_cfg_byte),
        .cfg_func (ctl_cfg_func)
    );

    hreq_route #(.DATA_W(DATA_W)) u_route (
        .req_valid (req_valid),
        .req_tag   (req_tag),
        .cls       (cls),
        .is_read   (is_read),
        .st        (st),
        .rd_busy   (rd_busy),
        .fwd_ready (fwd_ready),
        .ctl_ready (ctl_ready),
        .rsp_ready (rsp_ready),
        .req_ready (req_ready),
        .fwd_valid (fwd_valid),
        .ctl_valid (ctl_valid),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    // A request is consumed when it is offered and its outlet is ready.
    assign acc = req_valid & req_ready;

    hreq_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .cls     (cls),
        .is_read (is_read),
        .abort   (xfer_abort),
        .rd_done (rd_done),
        .st      (st),
        .rd_busy (rd_busy)
    );

    assign fwd_tag  = req_tag;
    assign fwd_data = req_data;
    assign rsp_tag  = RSP_STATUS;
endmodule

// File: rtl/hreq_seq_guard_chk.sv
// Temporal checks on the sequence guard, bound into every instance.
module hreq_seq_guard_chk
    import hreq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] req_tag,
    input logic       req_cmd0,
    input logic       xfer_abort,
    input logic       fwd_valid,
    input logic       fwd_ready,
    input logic [2:0] fwd_tag,
    input logic       ctl_valid,
    input logic       rsp_valid,
    input logic       rsp_ill,
    input logic       rsp_fl,
    input seq_state_t st,
    input logic       rd_busy
);
    // R4: a consumed address leaves a burst open.
    p_addr_opens_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_IDLE && req_valid && req_ready && req_tag[2:1] == 2'b01) |=> st == SQ_BURST);

    // R6: after a closing word is forwarded, no data is forwarded next.
    p_no_data_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_ready && fwd_tag[2:1] == 2'b11) |=> !(fwd_valid && fwd_tag[2]));

    // R7: abort during an open burst starts flushing.
    p_abort_flushes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_BURST && xfer_abort && !(req_valid && req_ready && req_tag[2:1] == 2'b11))
        |=> st == SQ_FLUSH);

    // R7: nothing reaches the master while flushing.
    p_flush_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st == SQ_FLUSH |-> !fwd_valid);

    // R9: a second read address is held off.
    p_read_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && st == SQ_IDLE && req_valid && req_tag[2:1] == 2'b01 && !req_cmd0)
        |-> (!req_ready && !fwd_valid && !rsp_valid));

    // R5: a response carries exactly one reason flag.
    p_one_reason_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_ill, rsp_fl}) == 1);

    // R10: a request goes to at most one outlet.
    p_one_outlet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_valid, ctl_valid, rsp_valid}));
endmodule

bind hreq_seq_guard hreq_seq_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_tag    (req_tag),
    .req_cmd0   (req_data[0]),
    .xfer_abort (xfer_abort),
    .fwd_valid  (fwd_valid),
    .fwd_ready  (fwd_ready),
    .fwd_tag    (fwd_tag),
    .ctl_valid  (ctl_valid),
    .rsp_valid  (rsp_valid),
    .rsp_ill    (rsp_data[16]),
    .rsp_fl     (rsp_data[19]),
    .st         (st),
    .rd_busy    (rd_busy)
);

// File: tb/test_hreq_seq_guard.sv
`timescale 1ns/1ps
module test_hreq_seq_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_tag = '0;
    logic [31:0] req_data = '0;
    logic        xfer_abort = 1'b0;
    logic        rd_done = 1'b0;
    logic        fwd_valid;
    logic        fwd_ready = 1'b1;
    logic [2:0]  fwd_tag;
    logic [31:0] fwd_data;
    logic        ctl_valid;
    logic        ctl_ready = 1'b1;
    logic        ctl_fence, ctl_cfg_wr, ctl_cfg_rd;
    logic [7:0]  ctl_cfg_addr, ctl_cfg_byte;
    logic [2:0]  ctl_cfg_func;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [3:0]  rsp_tag;
    logic [31:0] rsp_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit jitter = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // reference state: 0 idle, 1 burst open, 2 flushing
    int  m_st = 0;
    bit  m_rdb = 1'b0;
    bit  m_acc = 1'b0;
    int  m_kind = 0;   // 0 none,1 addr,2 data,3 last
    bit  m_read = 1'b0;
    bit  m_abort = 1'b0;
    bit  m_done = 1'b0;

    always #4 clk = ~clk;

    hreq_seq_guard i_hreq_seq_guard (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag), .req_data(req_data),
        .xfer_abort(xfer_abort), .rd_done(rd_done),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_tag(fwd_tag), .fwd_data(fwd_data),
        .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_fence(ctl_fence),
        .ctl_cfg_wr(ctl_cfg_wr), .ctl_cfg_rd(ctl_cfg_rd), .ctl_cfg_addr(ctl_cfg_addr),
        .ctl_cfg_byte(ctl_cfg_byte), .ctl_cfg_func(ctl_cfg_func),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference model: expected outputs for the current inputs, compared mid-cycle.
    always @(negedge clk) begin
        bit e_f, e_c, e_r, e_rdy;
        logic [31:0] e_rd;
        string rq;
        e_f = 0; e_c = 0; e_r = 0; e_rdy = 0; e_rd = {29'd0, req_tag};
        m_kind = 0; m_read = !req_data[0];
        rq = "R4";
        if (!rst_n) begin
            m_acc = 0;
        end else begin
            if (req_tag == 0) begin
                e_rdy = 1; rq = "R2";
            end else if (req_tag == 1) begin
                e_c = req_valid; e_rdy = ctl_ready; rq = "R3";
            end else if (req_tag <= 3) begin
                m_kind = 1;
                if (m_st == 0) begin
                    if (m_read && m_rdb) rq = "R9";
                    else begin e_f = req_valid; e_rdy = fwd_ready; end
                end else begin
                    e_r = req_valid; e_rd[16] = 1; e_rdy = rsp_ready; rq = "R5";
                end
            end else begin
                m_kind = (req_tag >= 6) ? 3 : 2;
                if (m_st == 1) begin e_f = req_valid; e_rdy = fwd_ready; end
                else if (m_st == 2) begin
                    e_r = req_valid; e_rd[19] = 1; e_rdy = rsp_ready; rq = "R7";
                end else begin
                    e_r = req_valid; e_rd[16] = 1; e_rdy = rsp_ready; rq = "R6";
                end
            end
            if (xfer_abort && (m_st == 0 || (m_st == 1 && m_kind == 3))) rq = "R8";
            if (!e_rdy && rq != "R9") rq = "R10";
            if (!req_valid) rq = "R1";
            chk(rq, {fwd_valid, ctl_valid, rsp_valid}, {e_f, e_c, e_r});
            if (req_valid) chk(rq, req_ready, e_rdy);
            if (e_f) chk(rq, {fwd_tag, fwd_data}, {req_tag, req_data});
            if (e_c) chk(rq, {ctl_fence, ctl_cfg_wr, ctl_cfg_rd, ctl_cfg_addr, ctl_cfg_byte, ctl_cfg_func},
                         {req_data[17:16] == 2'b00, req_data[16], req_data[17],
                          req_data[7:0], req_data[15:8], req_data[20:18]});
            if (e_r) chk(rq, {rsp_tag, rsp_data}, {4'h3, e_rd});
            m_acc = req_valid && e_rdy;
        end
        m_abort = xfer_abort;
        m_done = rd_done;
    end

    // Reference model: state update at the clock edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_st <= 0; m_rdb <= 0;
        end else begin
            if (m_st == 0 && m_acc && m_kind == 1 && m_read) m_rdb <= 1;
            else if (m_done) m_rdb <= 0;
            case (m_st)
                0: if (m_acc && m_kind == 1) m_st <= 1;
                1: if (m_acc && m_kind == 3) m_st <= 0; else if (m_abort) m_st <= 2;
                default: if (m_acc && m_kind == 3) m_st <= 0;
            endcase
        end
    end

    // Outlet ready pattern: all ready, or pseudo-random when jitter is on.
    initial forever begin
        @(posedge clk); #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (jitter) {fwd_ready, ctl_ready, rsp_ready} = lfsr[2:0] | {lfsr[5], 2'b0};
        else        {fwd_ready, ctl_ready, rsp_ready} = 3'b111;
    end

    // Watchdog.
    initial begin
        wait (cycles > 20000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic put(input logic [2:0] t, input logic [31:0] d, input bit ab = 1'b0);
        req_tag = t; req_data = d; req_valid = 1; xfer_abort = ab;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1;
        req_valid = 0; xfer_abort = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_abort();
        xfer_abort = 1; idle(1); xfer_abort = 0;
    endtask

    initial begin
        idle(3);
        rst_n = 1; idle(2);                          // R1: quiet after reset
        put(0, 32'h1234_5678);                       // R2: spare
        put(4, 32'h0);                               // R2: state still idle -> illegal (R6)
        put(1, 32'h0000_0000);                       // R3: fence
        put(1, 32'h0015_AB3C);                       // R3: cfg write func 5
        put(1, 32'h000E_0010);                       // R3: cfg read func 3
        put(1, 32'h0003_7701);                       // R3: both bits
        put(3, 32'h8000_0007);                       // R4: write address
        put(1, 32'h0000_0000);                       // R3: control inside burst
        put(4, 32'hDEAD_0001); put(5, 32'hDEAD_0002); put(7, 32'hDEAD_0003);
        put(2, 32'h4000_0006);                       // R9: read address
        put(6, 32'h1);
        req_tag = 2; req_data = 32'h4000_0010; req_valid = 1;   // R9: stalled read
        idle(4); rd_done = 1; idle(1); rd_done = 0;
        forever begin @(negedge clk); if (req_ready) break; end
        @(posedge clk); #1; req_valid = 0;
        put(6, 32'h2);
        put(2, 32'h0000_0001);                       // R9: write not stalled (read busy)
        put(6, 32'h3);
        rd_done = 1; idle(1); rd_done = 0;
        put(2, 32'h5); put(3, 32'h7);                // R5: address then address
        put(4, 32'h9); put(2, 32'hB);                // R5: data then address
        put(6, 32'hC); put(4, 32'hD);                // R6: closing then data
        put(7, 32'hE);                               // R6: closing then closing
        put(2, 32'h21); put(4, 32'h22);              // R7: abort mid-burst
        pulse_abort();
        put(4, 32'h23); put(1, 32'h0001_0005); put(5, 32'h24); put(2, 32'h25); put(6, 32'h26);
        put(4, 32'h27);                              // back to idle: illegal
        put(2, 32'h31); put(6, 32'h32, 1'b1);        // R8: abort with closing
        put(2, 32'h33); put(6, 32'h34);              // burst works after
        pulse_abort();                               // R8: abort while idle
        put(4, 32'h35);
        put(2, 32'h41); put(6, 32'h42); rd_done = 1; idle(1); rd_done = 0;
        jitter = 1;                                  // R10: back-pressure
        for (int i = 0; i < 40; i++) begin
            put(1, {12'd0, i[1:0], i[17:0]});
            put(3, 32'h1 | i);
            put(4, i); put(5, i + 1);
            if (i % 3 == 0) pulse_abort();
            put(6, i); put(7, i);
        end
        jitter = 0; idle(3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule